// File: doc/BRIEF.md
# Quarter-Rate Bang-Bang Phase Detector

This block turns eight digitised samples per quarter-rate clock period into early/late decisions for a charge-pump style loop. The samples are evenly spaced at one eighth of the period. Even indices fall on bit boundaries and are the edge samples. Odd indices fall in bit centres and are the centre samples. Index 0 is the earliest sample and index 7 the latest. Each quarter-rate period therefore carries four bits.

Only four comparisons are made: each edge sample against the centre sample that follows it. The boundaries between neighbouring pairs are never compared. This halves the decision rate per bit slot and keeps the ripple on the control path low. When a pair shows a transition, the edge sample is compared with the preceding centre sample, and that comparison casts an up or a down vote for that pair.

The four votes are then reduced to a net direction. That direction drives a three-level step (−1, 0, +1). The step reaches full scale only when two consecutive accepted sample vectors agree in direction. The centre samples also leave the block as a retimed 4-bit word, which gives the 1:4 demultiplexed data for free. The sample stream has a valid strobe but no back-pressure: every vector presented with valid high is accepted in that cycle. Results are announced one cycle later by a matching valid pulse.

Top module: `qpd_top`

## Requirements
- R1: While reset is sampled high at a clock edge, the next cycle shows out_valid_o low, all votes low, step_o zero and word_o zero. The stored previous centre sample and the stored previous direction are both cleared to zero.
- R2: Sample pairs (0,1), (2,3), (4,5) and (6,7) are compared, and pair k drives vote bit k. Differences between samples 1/2, 3/4, 5/6 and 7/0 produce no vote.
- R3: When pair k shows a transition, the prior sample is index 2k−1; for pair 0 it is index 7 of the previously accepted vector. If the edge sample equals the prior sample, vote_dn_o[k] is set (late). Otherwise vote_up_o[k] is set (early).
- R4: A pair whose two samples are equal sets neither vote. vote_up_o[k] and vote_dn_o[k] are never both high.
- R5: The net direction is +1 if more up than down votes are set, −1 if more down votes are set, and 0 on a tie. step_o equals this direction only when it is non-zero and equal to the direction of the previously accepted vector; otherwise step_o is 0. step_o is 2-bit two's complement: 01 = +1, 11 = −1, 00 = 0.
- R6: word_o[k] carries centre sample 2k+1, so bit 0 is the earliest-arriving bit.
- R7: All outputs are registered. An accepted vector is reflected on the outputs in the next cycle, with out_valid_o high for exactly that cycle.
- R8: A cycle with samp_valid_i low changes no output and drops out_valid_o. It also leaves the stored previous centre sample and previous direction untouched.
- R9: The first accepted vector after reset always gives step_o = 0, whatever its votes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quarter-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| samp_i | input | 8 | Samples, index 0 earliest; even = edge, odd = centre |
| samp_valid_i | input | 1 | samp_i holds a vector to accept this cycle |
| vote_up_o | output | 4 | Per-pair early vote |
| vote_dn_o | output | 4 | Per-pair late vote |
| step_o | output | 2 | Signed three-level phase-error step |
| word_o | output | 4 | Retimed centre samples, bit 0 first in time |
| out_valid_o | output | 1 | Outputs carry the result of the previous cycle's vector |

## Verification
Votes, step, word and out_valid all come from a single register stage, so each result is due in the cycle after its vector is accepted. The step also depends on the direction of the vector accepted before that, so step checks rely on a known sequence of vectors. The bench drives each vector on a falling edge and reads the outputs on the following falling edge, half a cycle after the registers update. For idle cycles it reads the outputs at the same point and compares them with the values left by the last accepted vector. It then feeds a further vector whose result depends on the stored history.

// File: rtl/qpd_pkg.sv
`timescale 1ns/1ps
package qpd_pkg;
  typedef logic signed [1:0] step_t;
  localparam step_t STEP_UP   = 2'sb01;
  localparam step_t STEP_DN   = 2'sb11;
  localparam step_t STEP_ZERO = 2'sb00;
endpackage

// File: rtl/qpd_pair_vote.sv
`timescale 1ns/1ps
// One edge/centre pair: a vote only on a transition inside the pair.
module qpd_pair_vote (
  input  logic edge_smp_i,
  input  logic centre_smp_i,
  input  logic prior_smp_i,
  output logic up_o,
  output logic dn_o
);
  logic trans;
  always_comb begin
    trans = edge_smp_i ^ centre_smp_i;
    dn_o  = trans & (edge_smp_i == prior_smp_i);
    up_o  = trans & (edge_smp_i != prior_smp_i);
  end
endmodule

// File: rtl/qpd_vote_merge.sv
`timescale 1ns/1ps
// Reduces per-pair votes to a direction and the two-in-a-row step.
module qpd_vote_merge
  import qpd_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic [NUM_PAIRS-1:0] up_i,
  input  logic [NUM_PAIRS-1:0] dn_i,
  input  step_t                prev_sign_i,
  output step_t                sign_o,
  output step_t                step_o
);
  localparam int CW = $clog2(NUM_PAIRS + 1);
  logic [CW-1:0] up_cnt, dn_cnt;

  always_comb begin
    up_cnt = '0;
    dn_cnt = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      up_cnt = up_cnt + CW'(up_i[i]);
      dn_cnt = dn_cnt + CW'(dn_i[i]);
    end
    if (up_cnt > dn_cnt)      sign_o = STEP_UP;
    else if (dn_cnt > up_cnt) sign_o = STEP_DN;
    else                      sign_o = STEP_ZERO;
    step_o = ((sign_o != STEP_ZERO) && (sign_o == prev_sign_i)) ? sign_o : STEP_ZERO;
  end
endmodule

// File: rtl/qpd_history.sv
`timescale 1ns/1ps
// Carries the last centre sample and last direction across accepted vectors.
module qpd_history
  import qpd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  load_i,
  input  logic  centre_i,
  input  step_t sign_i,
  output logic  prev_centre_o,
  output step_t prev_sign_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_centre_o <= 1'b0;
      prev_sign_o   <= STEP_ZERO;
    end else if (load_i) begin
      prev_centre_o <= centre_i;
      prev_sign_o   <= sign_i;
    end
  end
endmodule

// File: rtl/qpd_top.sv
`timescale 1ns/1ps
module qpd_top
  import qpd_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [2*NUM_PAIRS-1:0] samp_i,
  input  logic                   samp_valid_i,
  output logic [NUM_PAIRS-1:0]   vote_up_o,
  output logic [NUM_PAIRS-1:0]   vote_dn_o,
  output logic [1:0]             step_o,
  output logic [NUM_PAIRS-1:0]   word_o,
  output logic                   out_valid_o
);
  localparam int NSAMP = 2 * NUM_PAIRS;

  logic [NUM_PAIRS-1:0] up_c, dn_c, word_c;
  logic                 prev_centre;
  step_t                prev_sign, cur_sign, step_c;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic prior;
    if (g == 0) begin : g_first
      assign prior = prev_centre;
    end else begin : g_rest
      assign prior = samp_i[2*g-1];
    end
    qpd_pair_vote u_vote (
      .edge_smp_i   (samp_i[2*g]),
      .centre_smp_i (samp_i[2*g+1]),
      .prior_smp_i  (prior),
      .up_o         (up_c[g]),
      .dn_o         (dn_c[g])
    );
    assign word_c[g] = samp_i[2*g+1];
  end

  qpd_vote_merge #(.NUM_PAIRS(NUM_PAIRS)) u_merge (
    .up_i        (up_c),
    .dn_i        (dn_c),
    .prev_sign_i (prev_sign),
    .sign_o      (cur_sign),
    .step_o      (step_c)
  );

  qpd_history u_hist (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .load_i        (samp_valid_i),
    .centre_i      (samp_i[NSAMP-1]),
    .sign_i        (cur_sign),
    .prev_centre_o (prev_centre),
    .prev_sign_o   (prev_sign)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vote_up_o   <= '0;
      vote_dn_o   <= '0;
      step_o      <= STEP_ZERO;
      word_o      <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= samp_valid_i;
      if (samp_valid_i) begin
        vote_up_o <= up_c;
        vote_dn_o <= dn_c;
        step_o    <= step_c;
        word_o    <= word_c;
      end
    end
  end
endmodule

// File: rtl/qpd_checker.sv
`timescale 1ns/1ps
module qpd_checker
  import qpd_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic [2*NUM_PAIRS-1:0] samp_i,
  input logic                   samp_valid_i,
  input logic [NUM_PAIRS-1:0]   vote_up_o,
  input logic [NUM_PAIRS-1:0]   vote_dn_o,
  input logic [1:0]             step_o,
  input logic [NUM_PAIRS-1:0]   word_o,
  input logic                   out_valid_o
);
  step_t last_sgn;
  logic  seen_out;
  step_t out_sgn;

  always_comb begin
    if ($countones(vote_up_o) > $countones(vote_dn_o))      out_sgn = STEP_UP;
    else if ($countones(vote_dn_o) > $countones(vote_up_o)) out_sgn = STEP_DN;
    else                                                     out_sgn = STEP_ZERO;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      last_sgn <= STEP_ZERO;
      seen_out <= 1'b0;
    end else if (out_valid_o) begin
      last_sgn <= out_sgn;
      seen_out <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!out_valid_o && vote_up_o == '0 && vote_dn_o == '0 && step_o == 2'b00 && word_o == '0)); // R1

  AST_VOTE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    (vote_up_o & vote_dn_o) == '0); // R4

  AST_STEP_TWO_UP: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && step_o == STEP_UP) |-> (out_sgn == STEP_UP && last_sgn == STEP_UP)); // R5

  AST_STEP_TWO_DN: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && step_o == STEP_DN) |-> (out_sgn == STEP_DN && last_sgn == STEP_DN)); // R5

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    samp_valid_i |=> out_valid_o); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !samp_valid_i |=> (!out_valid_o && $stable(step_o) && $stable(word_o)
                       && $stable(vote_up_o) && $stable(vote_dn_o))); // R8

  AST_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !seen_out) |-> step_o == STEP_ZERO); // R9

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_word
    AST_WORD_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
      samp_valid_i |=> word_o[g] == $past(samp_i[2*g+1])); // R6
  end
endmodule

bind qpd_top qpd_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .samp_i       (samp_i),
  .samp_valid_i (samp_valid_i),
  .vote_up_o    (vote_up_o),
  .vote_dn_o    (vote_dn_o),
  .step_o       (step_o),
  .word_o       (word_o),
  .out_valid_o  (out_valid_o)
);

// File: tb/qpd_top_test.sv
`timescale 1ns/1ps
module qpd_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] samp = 8'h00;
  logic       vld = 1'b0;
  logic [3:0] up, dn, word;
  logic [1:0] step;
  logic       ovld;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  qpd_top uut (
    .clk_i (clk), .rst_i (rst), .samp_i (samp), .samp_valid_i (vld),
    .vote_up_o (up), .vote_dn_o (dn), .step_o (step), .word_o (word),
    .out_valid_o (ovld)
  );

  // Entry: samples, up votes, down votes, step, word.
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {8'h00, 4'b0000, 4'b0000, 2'b00, 4'b0000},  // R4 no transitions
    {8'h55, 4'b1111, 4'b0000, 2'b00, 4'b0000},  // R3 early, first of a run
    {8'h55, 4'b1111, 4'b0000, 2'b01, 4'b0000},  // R5 second up -> +1
    {8'h66, 4'b0000, 4'b1111, 2'b00, 4'b0101},  // R3 late, direction flip
    {8'h66, 4'b0000, 4'b1111, 2'b11, 4'b0101},  // R5 second down -> -1
    {8'h79, 4'b0001, 4'b1010, 2'b11, 4'b0110},  // R5 mixed, net down
    {8'hAA, 4'b1110, 4'b0001, 2'b00, 4'b1111},  // R3 pair 0 uses stored centre
    {8'h01, 4'b0000, 4'b0001, 2'b00, 4'b0000},  // R3 stored centre = 1
    {8'h01, 4'b0001, 4'b0000, 2'b00, 4'b0000},  // R3 stored centre = 0
    {8'h33, 4'b0000, 4'b0000, 2'b00, 4'b0101}   // R2 boundary-only changes
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [3:0] eu, input logic [3:0] ed,
                         input logic [1:0] es, input logic [3:0] ew, input logic ev);
    chk(req, "out_valid", int'(ovld), int'(ev));
    chk(req, "vote_up",   int'(up),   int'(eu));
    chk(req, "vote_dn",   int'(dn),   int'(ed));
    chk(req, "step",      int'(step), int'(es));
    chk(req, "word",      int'(word), int'(ew));
  endtask

  // Drive one vector on a falling edge, read its result on the next falling edge.
  task automatic push(input logic [7:0] s, input logic v);
    samp = s;
    vld  = v;
    @(negedge clk);
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk_all("R1", 4'h0, 4'h0, 2'b00, 4'h0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][21:14], 1'b1);
      chk_all((i == 0) ? "R9" : "R5", VEC[i][13:10], VEC[i][9:6], VEC[i][5:4], VEC[i][3:0], 1'b1);
    end
    // R8: idle cycle with changing samples leaves everything as after 8'h33.
    push(8'hFF, 1'b0);
    chk_all("R8", 4'h0, 4'h0, 2'b00, 4'h5, 1'b0);
    // Stored centre still 0: 8'h55 votes all up; previous direction 0 -> step 0.
    push(8'h55, 1'b1);
    chk_all("R8", 4'hF, 4'h0, 2'b00, 4'h0, 1'b1);
    push(8'hAA, 1'b0);
    push(8'hFF, 1'b0);
    chk_all("R8", 4'hF, 4'h0, 2'b00, 4'h0, 1'b0);
    // Direction +1 survived the idle cycles.
    push(8'h55, 1'b1);
    chk_all("R8", 4'hF, 4'h0, 2'b01, 4'h0, 1'b1);
    // R1 mid-stream reset, then R9 first vector gives no step.
    rst = 1'b1;
    push(8'h00, 1'b0);
    chk_all("R1", 4'h0, 4'h0, 2'b00, 4'h0, 1'b0);
    rst = 1'b0;
    push(8'h55, 1'b1);
    chk_all("R9", 4'hF, 4'h0, 2'b00, 4'h0, 1'b1);
    push(8'h55, 1'b1);
    chk_all("R5", 4'hF, 4'h0, 2'b01, 4'h0, 1'b1);
    // R7: out_valid lasts one cycle only.
    push(8'h00, 1'b0);
    chk("R7", "out_valid", int'(ovld), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule